// File: doc/BRIEF.md
# Per-Pipe Interrupt Status Register Bank

This block stores the interrupt status of a USB peripheral controller's data pipes. There are three status sets, each with one bit per pipe: buffer ready, not ready and buffer empty. A one-cycle event pulse from the pipe logic sets the bit for that pipe. Software reads the sets over a synchronous 16-bit register port. It clears a bit by writing 0 to it, and writing 1 leaves the bit unchanged.

A primary interrupt status register holds three summary flags and a start-of-frame bit. Each summary flag is the OR of one status set masked by its per-pipe enable register. A mirror register at a second address shows the same four bits from the same storage, so a clear written through either address acts on that one storage. The active-high interrupt request is the OR of the three summary flags.

Top module: `pipe_irq_bank`

## Requirements
- R1: After reset, every status bit, every enable mask, `cpu_rdata` and `irq` are 0.
- R2: A 1 on bit n of `ev_ready`, `ev_notready` or `ev_empty` sets bit n of the status register at byte address 0x46, 0x48 or 0x4A respectively. A later read of that register returns the bit as 1.
- R3: A write to a status register clears every bit 7..0 whose data bit is 0. Bits whose data bit is 1 keep their value.
- R4: Bits 15..8 of every register read back as 0. Writing to those bits has no effect.
- R5: If a set pulse and a clearing write reach the same bit in the same cycle, the bit ends up 1.
- R6: Clearing writes to one register in consecutive cycles each take effect. Each one acts on the result of the write before it.
- R7: The primary register at 0x40 reads bit 0 as OR(ready status AND ready enable), bit 1 as the same for not ready, bit 2 as the same for empty, and bit 7 as the start-of-frame flag. Writes to bits 0..2 have no effect. The enable masks are at 0x36, 0x38 and 0x3A, and they read back as written in bits 7..0.
- R8: The mirror register at 0x42 reads the same bits 0, 1, 2 and 7 as 0x40. A 1 on `ev_frame` sets the start-of-frame flag. Writing 0 to bit 7 at either 0x40 or 0x42 clears it.
- R9: `irq` is 1 exactly when at least one of the three summary flags is 1.
- R10: `cpu_rdata` is registered. It shows the register addressed in a cycle from the next clock edge, with the values held before that edge. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Write strobe for one cycle |
| cpu_addr | input | 8 | Byte address of the register |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| ev_ready | input | 8 | Per-pipe buffer-ready set pulses |
| ev_notready | input | 8 | Per-pipe not-ready set pulses |
| ev_empty | input | 8 | Per-pipe buffer-empty set pulses |
| ev_frame | input | 1 | Start-of-frame set pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
A set pulse or a write that is applied in one cycle changes the status storage at the next clock edge. `irq` follows from that storage at the same edge, because it is combinational from the status and enable registers. A read presented in a cycle shows its data one edge later. So every read that checks a result is issued in a cycle after the stimulus has been deasserted. The bench samples `cpu_rdata` and `irq` just after the edge that loads the read data. The set-versus-clear case and the back-to-back clears are driven in adjacent cycles with no gap, and only the final state is read.

// File: rtl/pirq_pkg.sv
// Package: shared constants of the pipe interrupt status bank.
// Assumes byte addressing with 16-bit registers at even addresses.
package pirq_pkg;
    localparam int DW       = 16;
    localparam int AW       = 8;
    localparam int NSETS    = 3;
    localparam int SUM_SOF  = 7;
    localparam logic [AW-1:0] A_PRIMARY = 8'h40;
    localparam logic [AW-1:0] A_MIRROR  = 8'h42;

    // Byte address of status set k (0 ready, 1 not ready, 2 empty).
    function automatic logic [AW-1:0] sts_addr(input int k);
        return 8'h46 + AW'(2 * k);
    endfunction

    // Byte address of the enable mask for status set k.
    function automatic logic [AW-1:0] en_addr(input int k);
        return 8'h36 + AW'(2 * k);
    endfunction
endpackage

// File: rtl/pirq_decode.sv
// Module: address decoder. Turns a CPU write into per-register strobes.
// Assumes cpu_we is high for exactly one cycle per write access.
module pirq_decode
    import pirq_pkg::*;
(
    input  logic              we,
    input  logic [AW-1:0]     addr,
    output logic [NSETS-1:0]  sts_wr,
    output logic [NSETS-1:0]  en_wr,
    output logic              frame_wr
);
    // Strobe generation for the status and enable registers.
    always_comb begin
        for (int k = 0; k < NSETS; k++) begin
            sts_wr[k] = we && (addr == sts_addr(k));
            en_wr[k]  = we && (addr == en_addr(k));
        end
    end

    // The primary and mirror registers share the frame flag.
    assign frame_wr = we && ((addr == A_PRIMARY) || (addr == A_MIRROR));
endmodule

// File: rtl/pirq_flagset.sv
// Module: a row of sticky flags. A set pulse from hardware raises a flag.
// A write strobe keeps only the flags whose keep bit is 1. Set wins.
module pirq_flagset #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] keep_i,
    output logic [W-1:0] q
);
    logic [W-1:0] kept;

    // Bits that survive a write of 0 (clear-only access).
    assign kept = wr_i ? (q & keep_i) : q;

    // Flag storage; hardware set is ORed after the clear so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= kept | set_i;
    end
endmodule

// File: rtl/pirq_rdmux.sv
// Module: registered read multiplexer for the register bank.
// Assumes PIPES <= 8, so that bits 15..8 of every register are 0.
module pirq_rdmux
    import pirq_pkg::*;
#(
    parameter int PIPES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               addr,
    input  logic [NSETS-1:0][PIPES-1:0] sts,
    input  logic [NSETS-1:0][PIPES-1:0] en,
    input  logic [NSETS-1:0]            summary,
    input  logic                        frame,
    output logic [DW-1:0]               rdata
);
    logic [DW-1:0] sel;

    // Pick the addressed register; unmapped addresses give 0.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NSETS; k++) begin
            if (addr == sts_addr(k)) sel[PIPES-1:0] = sts[k];
            if (addr == en_addr(k))  sel[PIPES-1:0] = en[k];
        end
        if ((addr == A_PRIMARY) || (addr == A_MIRROR)) begin
            sel[NSETS-1:0] = summary;
            sel[SUM_SOF]   = frame;
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= sel;
    end
endmodule

// File: rtl/pipe_irq_bank.sv
// Module: per-pipe interrupt status bank, the top of the block.
// Holds three clear-on-write-0 status sets with enable masks, a
// start-of-frame flag seen at two addresses, summary flags and irq.
// Assumes event inputs are synchronous to clk; PIPES <= 8.
module pipe_irq_bank
    import pirq_pkg::*;
#(
    parameter int PIPES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    input  logic [PIPES-1:0] ev_ready,
    input  logic [PIPES-1:0] ev_notready,
    input  logic [PIPES-1:0] ev_empty,
    input  logic             ev_frame,
    output logic             irq
);
    logic [NSETS-1:0][PIPES-1:0] ev_all;
    logic [NSETS-1:0][PIPES-1:0] sts;
    logic [NSETS-1:0][PIPES-1:0] en;
    logic [NSETS-1:0]            sts_wr;
    logic [NSETS-1:0]            en_wr;
    logic [NSETS-1:0]            summary;
    logic                        frame_wr;
    logic                        frame;

    // Gather the event pulses in set order.
    assign ev_all[0] = ev_ready;
    assign ev_all[1] = ev_notready;
    assign ev_all[2] = ev_empty;

    pirq_decode u_dec (
        .we       (cpu_we),
        .addr     (cpu_addr),
        .sts_wr   (sts_wr),
        .en_wr    (en_wr),
        .frame_wr (frame_wr)
    );

    generate
        for (genvar k = 0; k < NSETS; k++) begin : g_set
            pirq_flagset #(.W(PIPES)) u_sts (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (ev_all[k]),
                .wr_i   (sts_wr[k]),
                .keep_i (cpu_wdata[PIPES-1:0]),
                .q      (sts[k])
            );

            // Enable mask register for this set.
            always_ff @(posedge clk) begin
                if (!rst_n)        en[k] <= '0;
                else if (en_wr[k]) en[k] <= cpu_wdata[PIPES-1:0];
            end

            // Summary flag of this set.
            assign summary[k] = |(sts[k] & en[k]);
        end
    endgenerate

    pirq_flagset #(.W(1)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_frame),
        .wr_i   (frame_wr),
        .keep_i (cpu_wdata[SUM_SOF]),
        .q      (frame)
    );

    pirq_rdmux #(.PIPES(PIPES)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cpu_addr),
        .sts     (sts),
        .en      (en),
        .summary (summary),
        .frame   (frame),
        .rdata   (cpu_rdata)
    );

    // Interrupt request from the summary flags.
    assign irq = |summary;
endmodule

// File: rtl/pipe_irq_bank_chk.sv
// Module: assertion checker for pipe_irq_bank, attached by bind.
module pipe_irq_bank_chk
    import pirq_pkg::*;
#(
    parameter int PIPES = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cpu_we,
    input logic [DW-1:0]               cpu_rdata,
    input logic [NSETS-1:0][PIPES-1:0] ev_all,
    input logic [NSETS-1:0][PIPES-1:0] sts,
    input logic [NSETS-1:0][PIPES-1:0] en,
    input logic                        irq
);
    // R2 and R5: an event always lands, even against a clearing write.
    a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((sts & $past(ev_all)) == $past(ev_all)));

    // R3: a status bit falls only after a CPU write.
    a_r3_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (((~sts & $past(sts)) == '0) || $past(cpu_we)));

    // R2: a status bit rises only after its event.
    a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((sts & ~$past(sts) & ~$past(ev_all)) == '0));

    // R4: upper half of read data is always 0.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[15:8] == 8'h00);

    // R9: irq tracks enabled pending status.
    a_r9_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(sts & en)));
endmodule

bind pipe_irq_bank pipe_irq_bank_chk #(.PIPES(PIPES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .ev_all    (ev_all),
    .sts       (sts),
    .en        (en),
    .irq       (irq)
);

// File: tb/pipe_irq_bank_tb.sv
module pipe_irq_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [P-1:0] ev [3];
    logic        ev_frame = 1'b0;
    logic        irq;
    int checks = 0;
    int errors = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pipe_irq_bank #(.PIPES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ev_ready(ev[0]), .ev_notready(ev[1]), .ev_empty(ev[2]),
        .ev_frame(ev_frame), .irq(irq)
    );

    function automatic logic [7:0] sa(input int k);
        return 8'h46 + 8'(2 * k);
    endfunction
    function automatic logic [7:0] ea(input int k);
        return 8'h36 + 8'(2 * k);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a;
        @(posedge clk);
        #1 d = cpu_rdata;
    endtask

    task automatic pulse(input int k, input logic [P-1:0] m);
        @(negedge clk);
        ev[k] = m;
        @(negedge clk);
        ev[k] = '0;
    endtask

    initial begin
        ev[0] = '0; ev[1] = '0; ev[2] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 3; k++) begin
            rd(sa(k), rv); check("R1 status", rv, 16'h0);
            rd(ea(k), rv); check("R1 enable", rv, 16'h0);
        end
        rd(8'h40, rv); check("R1 primary", rv, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);

        // R2/R3: per pipe set, write-1 ignored, write-0 clears
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < P; n++) begin
                pulse(k, P'(1) << n);
                rd(sa(k), rv); check("R2 set bit", rv, 16'(1) << n);
                wr(sa(k), 16'hFFFF);
                rd(sa(k), rv); check("R3 write1 keeps", rv, 16'(1) << n);
                wr(sa(k), ~(16'(1) << n));
                rd(sa(k), rv); check("R3 write0 clears", rv, 16'h0);
            end
        end

        // R4: upper bits read 0, writes to them do nothing
        pulse(1, 8'hFF);
        wr(sa(1), 16'h00FF);
        rd(sa(1), rv); check("R4 status upper", rv, 16'h00FF);
        wr(sa(1), 16'hFF00);
        rd(sa(1), rv); check("R4 upper ignored, low cleared", rv, 16'h0000);
        wr(ea(2), 16'hFFFF);
        rd(ea(2), rv); check("R4 enable upper", rv, 16'h00FF);
        wr(ea(2), 16'h0000);

        // R5: set and clear in the same cycle, set wins
        pulse(0, 8'h24);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = sa(0); cpu_wdata = 16'h0000; ev[0] = 8'h04;
        @(negedge clk);
        cpu_we = 1'b0; ev[0] = '0;
        rd(sa(0), rv); check("R5 set wins", rv, 16'h0004);
        wr(sa(0), 16'h0);

        // R6: back-to-back clears, one pipe per cycle
        pulse(2, 8'hFF);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = sa(2);
        for (int n = 0; n < 4; n++) begin
            cpu_wdata = ~(16'(1) << n);
            @(negedge clk);
        end
        cpu_we = 1'b0;
        rd(sa(2), rv); check("R6 half cleared", rv, 16'h00F0);
        @(negedge clk);
        cpu_we = 1'b1;
        for (int n = 4; n < 8; n++) begin
            cpu_wdata = ~(16'(1) << n);
            @(negedge clk);
        end
        cpu_we = 1'b0;
        rd(sa(2), rv); check("R6 all cleared", rv, 16'h0000);

        // R7/R9: summary flags and irq over pipe x enable sweep
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < P; n++) begin
                pulse(k, P'(1) << n);
                for (int m = 0; m < P; m++) begin
                    wr(ea(k), 16'(1) << m);
                    rd(8'h40, rv);
                    check("R7 summary", rv, (n == m) ? (16'(1) << k) : 16'h0);
                    check("R9 irq", {15'h0, irq}, {15'h0, n == m});
                end
                wr(ea(k), 16'h0);
                rd(8'h40, rv); check("R9 disabled", {15'h0, irq}, 16'h0);
                wr(sa(k), 16'h0);
            end
        end

        // R7: writes to summary bits ignored, status untouched
        pulse(0, 8'h01);
        wr(ea(0), 16'h0001);
        wr(8'h40, 16'h0000);
        rd(8'h40, rv); check("R7 summary write ignored", rv, 16'h0001);
        rd(sa(0), rv); check("R7 status untouched", rv, 16'h0001);

        // R8: mirror register and frame flag
        pulse(0, 8'h00);
        @(negedge clk) ev_frame = 1'b1;
        @(negedge clk) ev_frame = 1'b0;
        rd(8'h40, rv); check("R8 primary frame", rv, 16'h0081);
        rd(8'h42, rv); check("R8 mirror same", rv, 16'h0081);
        wr(8'h42, 16'h0000);
        rd(8'h40, rv); check("R8 mirror clears", rv, 16'h0001);
        @(negedge clk) ev_frame = 1'b1;
        @(negedge clk) ev_frame = 1'b0;
        wr(8'h40, 16'h0080);
        rd(8'h42, rv); check("R8 write1 keeps", rv, 16'h0081);
        wr(8'h40, 16'h0000);
        rd(8'h42, rv); check("R8 primary clears", rv, 16'h0001);

        // R10: registered read shows pre-edge value; unmapped is 0
        @(negedge clk);
        cpu_addr = sa(0); cpu_we = 1'b1; cpu_wdata = 16'h0;
        @(posedge clk);
        #1 check("R10 read before write lands", cpu_rdata, 16'h0001);
        @(negedge clk) cpu_we = 1'b0;
        rd(sa(0), rv); check("R10 after write", rv, 16'h0000);
        rd(8'h50, rv); check("R10 unmapped", rv, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule